// File: doc/BRIEF.md
# Serial Port Data FIFO Interface

This block is the data side of a synchronous serial port. It sits between a simple register bus and the serial shifter. A bus write to the data offset puts one word into a transmit queue. A bus read from the same offset takes one word out of a receive queue. The shifter takes transmit words one at a time and hands over each received frame as a word.

Words are trimmed to the programmed frame length in both directions, so the bit positions above the frame are always zero. In the three-wire control format, transmit words always keep only their low byte. Received words still follow the programmed length in that format.

Both queues keep their contents while the port enable is low. Software can therefore preload transmit data and then start the port. A sticky overrun flag records any receive frame that was lost because the receive queue was full.

Top module: `sspdata_port`

## Requirements
- R1: A bus access with `bus_sel`=1 and `bus_wr`=1 at offset 0x008 pushes one word into the transmit queue on that clock edge. A write to any other offset changes nothing.
- R2: `frame_m1` holds the frame length minus one. Values below 3 count as 3, giving a 4-bit frame. A pushed transmit word keeps bits [frame_m1:0] of `bus_wdata` and stores zero above them. `bus_wdata[31:16]` never reaches the queue.
- R3: When `frame_fmt`=2'b10 (three-wire control format), transmit words keep only bits 7:0, whatever the value of `frame_m1`.
- R4: A received word is stored right-justified with bits above the frame length forced to zero. This applies in every format, including 2'b01 (synchronous-frame format) and 2'b10.
- R5: A bus read (`bus_sel`=1, `bus_wr`=0) at offset 0x008 returns the oldest receive word on `bus_rdata[15:0]` in the same cycle, with bits 31:16 zero, and removes that word at the clock edge. A read at any other offset returns 0 and removes nothing.
- R6: A read of the data offset while the receive queue is empty returns 0 and leaves the queue unchanged.
- R7: Each queue holds 8 words. A bus write while the transmit queue is full is dropped.
- R8: A receive push while the receive queue is full is discarded and sets `rx_overrun`. The flag stays set until `ovr_clr` is pulsed. A set in the same cycle as a clear wins.
- R9: The status outputs reflect the queue fill levels: `tx_empty`, `tx_not_full`, `rx_not_empty` and `rx_full`. After reset both queues are empty and `rx_overrun` is 0.
- R10: While `port_en`=0, `tx_pull` and `rx_push` are ignored and both queues keep their contents. Bus writes are still accepted.
- R11: `tx_word` shows the oldest transmit word, or 0 when the queue is empty. Each `tx_pull` with `port_en`=1 removes exactly one word, so words leave in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| port_en | input | 1 | Port enable for the shifter side |
| frame_m1 | input | 4 | Frame length minus one |
| frame_fmt | input | 2 | 00 clocked-serial, 01 synchronous-frame, 10 three-wire control |
| tx_pull | input | 1 | Shifter takes the current transmit word |
| tx_word | output | 16 | Oldest transmit word, 0 when empty |
| rx_push | input | 1 | Shifter delivers a received frame |
| rx_word | input | 16 | Received frame, right-justified |
| ovr_clr | input | 1 | Clears the overrun flag |
| tx_empty | output | 1 | Transmit queue empty |
| tx_not_full | output | 1 | Transmit queue has room |
| rx_not_empty | output | 1 | Receive queue holds data |
| rx_full | output | 1 | Receive queue full |
| rx_overrun | output | 1 | Sticky lost-frame flag |

## Verification
Read data is combinational, so `bus_rdata` is sampled inside the read cycle, a little after the falling edge on which the read is driven. Every queue effect settles on the rising edge that ends the access: writes, pulls, pushes, pops and overrun set or clear. Those effects, including `tx_word` and the flags, are therefore sampled at the next falling edge. Inputs are always driven on falling edges, so no check is made at the edge where a value changes.

// File: rtl/sspdata_pkg.sv
package sspdata_pkg;
  typedef enum logic [1:0] {
    FMT_CLKSER = 2'b00,
    FMT_SYNFRM = 2'b01,
    FMT_3WIRE  = 2'b10,
    FMT_RSVD   = 2'b11
  } frame_fmt_e;

  localparam int unsigned WORD_BITS = 16;
  localparam int unsigned MIN_FRAME = 4;
  localparam int unsigned WIRE3_BITS = 8;
endpackage

// File: rtl/sspdata_mask.sv
module sspdata_mask
  import sspdata_pkg::*;
#(
  parameter int unsigned W       = WORD_BITS,
  parameter int unsigned MIN_LEN = MIN_FRAME,
  parameter int unsigned W3_LEN  = WIRE3_BITS,
  localparam int unsigned FS_W   = $clog2(W)
) (
  input  logic [FS_W-1:0] frame_m1,
  input  frame_fmt_e      fmt,
  output logic [W-1:0]    tx_mask,
  output logic [W-1:0]    rx_mask
);
  logic [FS_W-1:0] eff_m1;
  logic            wire3;

  always_comb begin
    eff_m1 = (frame_m1 < FS_W'(MIN_LEN - 1)) ? FS_W'(MIN_LEN - 1) : frame_m1;
    wire3  = (fmt == FMT_3WIRE);
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign rx_mask[i] = (FS_W'(i) <= eff_m1);
    assign tx_mask[i] = wire3 ? (i < W3_LEN) : rx_mask[i];
  end
endmodule

// File: rtl/sspdata_fifo.sv
module sspdata_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 16,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] level
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_n, rd_ptr_q, rd_ptr_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          do_push, do_pop;

  always_comb begin
    empty   = (cnt_q == '0);
    full    = (cnt_q == CW'(DEPTH));
    do_push = push && !full;
    do_pop  = pop && !empty;
    wr_ptr_n = wr_ptr_q;
    rd_ptr_n = rd_ptr_q;
    cnt_n    = cnt_q;
    if (do_push) wr_ptr_n = (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
    if (do_pop)  rd_ptr_n = (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
    case ({do_push, do_pop})
      2'b10:   cnt_n = cnt_q + 1'b1;
      2'b01:   cnt_n = cnt_q - 1'b1;
      default: cnt_n = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_n;
      rd_ptr_q <= rd_ptr_n;
      cnt_q    <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q] <= din;
  end

  assign head  = mem[rd_ptr_q];
  assign level = cnt_q;

  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH)); // R7
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> ($stable(cnt_q) && $stable(wr_ptr_q))); // R7
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> ($stable(rd_ptr_q) && empty)); // R6
endmodule

// File: rtl/sspdata_port.sv
module sspdata_port
  import sspdata_pkg::*;
#(
  parameter int unsigned DEPTH    = 8,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned BUS_W    = 32,
  parameter logic [11:0] DATA_OFS = 12'h008,
  localparam int unsigned W       = WORD_BITS,
  localparam int unsigned FS_W    = $clog2(W),
  localparam int unsigned CW      = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              port_en,
  input  logic [FS_W-1:0]   frame_m1,
  input  logic [1:0]        frame_fmt,
  input  logic              tx_pull,
  output logic [W-1:0]      tx_word,
  input  logic              rx_push,
  input  logic [W-1:0]      rx_word,
  input  logic              ovr_clr,
  output logic              tx_empty,
  output logic              tx_not_full,
  output logic              rx_not_empty,
  output logic              rx_full,
  output logic              rx_overrun
);
  logic [W-1:0]  tx_mask, rx_mask, tx_head, rx_head;
  logic          bus_hit, tx_wr, rx_rd, tx_pop_g, rx_push_g;
  logic          tx_full_i, rx_empty_i;
  logic [CW-1:0] tx_level, rx_level;
  logic          ovr_q, ovr_n;

  sspdata_mask #(.W(W)) u_mask (
    .frame_m1 (frame_m1),
    .fmt      (frame_fmt_e'(frame_fmt)),
    .tx_mask  (tx_mask),
    .rx_mask  (rx_mask)
  );

  always_comb begin
    bus_hit   = bus_sel && (bus_addr == ADDR_W'(DATA_OFS));
    tx_wr     = bus_hit && bus_wr;
    rx_rd     = bus_hit && !bus_wr;
    tx_pop_g  = port_en && tx_pull;
    rx_push_g = port_en && rx_push;
  end

  sspdata_fifo #(.DEPTH(DEPTH), .W(W)) u_txq (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (tx_wr),
    .din   (bus_wdata[W-1:0] & tx_mask),
    .pop   (tx_pop_g),
    .head  (tx_head),
    .empty (tx_empty),
    .full  (tx_full_i),
    .level (tx_level)
  );

  sspdata_fifo #(.DEPTH(DEPTH), .W(W)) u_rxq (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (rx_push_g),
    .din   (rx_word & rx_mask),
    .pop   (rx_rd),
    .head  (rx_head),
    .empty (rx_empty_i),
    .full  (rx_full),
    .level (rx_level)
  );

  always_comb begin
    tx_not_full  = !tx_full_i;
    rx_not_empty = !rx_empty_i;
    tx_word      = tx_empty ? '0 : tx_head;
    bus_rdata    = (rx_rd && !rx_empty_i) ? {{(BUS_W - W){1'b0}}, rx_head} : '0;
  end

  always_comb begin
    ovr_n = ovr_q;
    if (ovr_clr) ovr_n = 1'b0;
    if (rx_push_g && rx_full) ovr_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr_q <= 1'b0;
    else        ovr_q <= ovr_n;
  end

  assign rx_overrun = ovr_q;

  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && rx_push && rx_full) |=> rx_overrun); // R8
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_overrun && !ovr_clr) |=> rx_overrun); // R8
  AST_DIS_KEEP_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_en && !tx_wr) |=> $stable(tx_level)); // R10
  AST_DIS_KEEP_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_en && !rx_rd) |=> $stable(rx_level)); // R10
  AST_MISS_NOREAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr != ADDR_W'(DATA_OFS) && !rx_push_g) |=> $stable(rx_level)); // R5
endmodule

// File: tb/sim_sspdata_port.sv
module sim_sspdata_port;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        port_en;
  logic [3:0]  frame_m1;
  logic [1:0]  frame_fmt;
  logic        tx_pull, rx_push, ovr_clr;
  logic [15:0] tx_word, rx_word;
  logic        tx_empty, tx_not_full, rx_not_empty, rx_full, rx_overrun;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  sspdata_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .port_en(port_en), .frame_m1(frame_m1), .frame_fmt(frame_fmt),
    .tx_pull(tx_pull), .tx_word(tx_word), .rx_push(rx_push), .rx_word(rx_word),
    .ovr_clr(ovr_clr), .tx_empty(tx_empty), .tx_not_full(tx_not_full),
    .rx_not_empty(rx_not_empty), .rx_full(rx_full), .rx_overrun(rx_overrun)
  );

  // {frame_m1[3:0], fmt[1:0], wdata[15:0], expected tx_word[15:0]}
  localparam logic [37:0] TXV [9] = '{
    {4'hF, 2'b00, 16'hABCD, 16'hABCD},   // R2 full width
    {4'h7, 2'b00, 16'hABCD, 16'h00CD},   // R2 8-bit
    {4'h3, 2'b00, 16'hABCD, 16'h000D},   // R2 4-bit
    {4'h0, 2'b00, 16'hABCD, 16'h000D},   // R2 clamp to 4
    {4'h8, 2'b00, 16'hFFFF, 16'h01FF},   // R2 9-bit
    {4'hB, 2'b01, 16'hFFFF, 16'h0FFF},   // R2 sync-frame fmt
    {4'hF, 2'b10, 16'h1234, 16'h0034},   // R3 three-wire
    {4'h3, 2'b10, 16'h12F5, 16'h00F5},   // R3 overrides small size
    {4'hE, 2'b11, 16'hFFFF, 16'h7FFF}    // R2 15-bit
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic pull();
    @(negedge clk); tx_pull = 1'b1;
    @(negedge clk); tx_pull = 1'b0;
  endtask

  task automatic rpush(input logic [15:0] w);
    @(negedge clk); rx_push = 1'b1; rx_word = w;
    @(negedge clk); rx_push = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0; bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    port_en = 1'b1; frame_m1 = 4'hF; frame_fmt = 2'b00;
    tx_pull = 0; rx_push = 0; rx_word = '0; ovr_clr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    chk(tx_empty && tx_not_full && !rx_not_empty && !rx_full && !rx_overrun,
        "R9 reset flags", {27'd0, tx_empty, tx_not_full, rx_not_empty, rx_full, rx_overrun},
        {27'd0, 5'b11000});
    chk(tx_word == 16'h0, "R11 empty tx_word", {16'd0, tx_word}, 32'd0);

    // R1 R2 R3 table walk
    foreach (TXV[i]) begin
      frame_m1  = TXV[i][37:34];
      frame_fmt = TXV[i][33:32];
      bus_write(12'h008, {16'hDEAD, TXV[i][31:16]});
      chk(tx_word == TXV[i][15:0], "R2/R3 tx mask", {16'd0, tx_word}, {16'd0, TXV[i][15:0]});
      pull();
      chk(tx_empty, "R11 pull empties", {31'd0, tx_empty}, 32'd1);
    end

    // R1 write at wrong offset ignored
    frame_m1 = 4'hF; frame_fmt = 2'b00;
    bus_write(12'h00C, 32'h0000_5A5A);
    chk(tx_empty && tx_word == 0, "R1 wrong offset write", {16'd0, tx_word}, 32'd0);

    // R6 empty read
    bus_read(12'h008, rd);
    chk(rd == 32'd0, "R6 empty read", rd, 32'd0);
    chk(!rx_not_empty, "R6 still empty", {31'd0, rx_not_empty}, 32'd0);

    // R4 masking on receive
    frame_m1 = 4'h7; frame_fmt = 2'b01;
    rpush(16'hBEEF);
    frame_m1 = 4'hB; frame_fmt = 2'b10;
    rpush(16'hFFFF);
    frame_m1 = 4'hF; frame_fmt = 2'b00;
    rpush(16'h1234);
    // R5 read at other offset returns zero, no pop
    bus_read(12'h004, rd);
    chk(rd == 32'd0, "R5 wrong offset read", rd, 32'd0);
    bus_read(12'h008, rd);
    chk(rd == 32'h0000_00EF, "R4 sync-frame 8-bit rx", rd, 32'h0000_00EF);
    bus_read(12'h008, rd);
    chk(rd == 32'h0000_0FFF, "R4 three-wire 12-bit rx", rd, 32'h0000_0FFF);
    bus_read(12'h008, rd);
    chk(rd == 32'h0000_1234, "R5 full-width rx", rd, 32'h0000_1234);
    chk(!rx_not_empty, "R5 drained", {31'd0, rx_not_empty}, 32'd0);

    // R7 transmit capacity and drop
    for (int k = 0; k < 9; k++) bus_write(12'h008, 32'h100 + k);
    chk(!tx_not_full, "R7 tx full", {31'd0, tx_not_full}, 32'd0);
    for (int k = 0; k < 8; k++) begin
      chk(tx_word == 16'h100 + k, "R11 tx order", {16'd0, tx_word}, 32'h100 + k);
      pull();
    end
    chk(tx_empty, "R7 ninth write dropped", {31'd0, tx_empty}, 32'd1);

    // R8 receive overrun
    for (int k = 0; k < 9; k++) rpush(16'h200 + k);
    chk(rx_full && rx_overrun, "R8 overrun set", {30'd0, rx_full, rx_overrun}, 32'd3);
    @(negedge clk);
    chk(rx_overrun, "R8 sticky", {31'd0, rx_overrun}, 32'd1);
    ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0;
    chk(!rx_overrun, "R8 cleared", {31'd0, rx_overrun}, 32'd0);
    for (int k = 0; k < 8; k++) begin
      bus_read(12'h008, rd);
      chk(rd == 32'h200 + k, "R8 rx order", rd, 32'h200 + k);
    end
    chk(!rx_not_empty && !rx_full, "R9 rx empty again", {30'd0, rx_not_empty, rx_full}, 32'd0);

    // R10 disabled port keeps data, ignores shifter
    port_en = 1'b0;
    bus_write(12'h008, 32'h0000_0A01);
    bus_write(12'h008, 32'h0000_0A02);
    pull();
    chk(tx_word == 16'h0A01, "R10 pull ignored", {16'd0, tx_word}, 32'h0A01);
    rpush(16'h0777);
    chk(!rx_not_empty, "R10 push ignored", {31'd0, rx_not_empty}, 32'd0);
    repeat (4) @(negedge clk);
    port_en = 1'b1;
    @(negedge clk);
    chk(tx_word == 16'h0A01 && !tx_empty, "R10 kept after enable", {16'd0, tx_word}, 32'h0A01);
    pull();
    chk(tx_word == 16'h0A02, "R11 next after enable", {16'd0, tx_word}, 32'h0A02);
    pull();
    chk(tx_empty, "R9 tx empty flag", {31'd0, tx_empty}, 32'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule